// File: doc/BRIEF.md
# Consecutive-Cycle Overcurrent Fault Latch

This block turns per-cycle current-limit flags from a group of power switches into one latched protection fault. A strobe marks the end of each switching cycle. On each strobe the block checks whether any switch reported a limit hit. An unbroken run of such cycles is counted, and once the run reaches the selected length the fault is set.

The run length can be set to a short or a long window. After the fault is set, it stays set even if the overcurrent goes away. Only an exit from the controlling operating mode clears it, for example leaving the charge state or entering high-impedance mode. That exit arrives as a single clear input.

While the fault is set, the block gates the converter enable request off and forces the charge-current request to zero.

Top module: `oc_run_fault`

## Requirements
- R1: After asynchronous reset the run count is 0, the fault is clear, and the enable and current requests pass through unchanged.
- R2: On a strobe where at least one bit of `lim_hit_i` is 1 and no clear is present, the run count goes up by one at that clock edge. The count saturates at 16.
- R3: On a strobe where every bit of `lim_hit_i` is 0 and no clear is present, the run count returns to 0.
- R4: Without a strobe, `lim_hit_i` and `run_sel_i` have no effect: the run count and the fault keep their values.
- R5: With `run_sel_i`=0 the fault sets at the edge of the 8th consecutive hit strobe and not before.
- R6: With `run_sel_i`=1 the fault sets at the edge of the 16th consecutive hit strobe and not before.
- R7: A hit on any switch continues the run, even when a different switch is flagged on each cycle.
- R8: Once set, the fault stays set through miss strobes and idle cycles until a clear arrives.
- R9: `mode_exit_i` clears the run count and the fault at the next edge. It takes priority over a hit strobe on the same clock, and the run then restarts from 0.
- R10: `run_sel_i` is applied at each strobe. A hit strobe whose new count is at or above the length selected at that strobe sets the fault.
- R11: While the fault is set, `conv_en_o` is 0 and `ichg_o` is 0. While it is clear, `conv_en_o` equals `conv_en_req_i` and `ichg_o` equals `ichg_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_stb_i | input | 1 | One-clock strobe at the end of each switching cycle |
| lim_hit_i | input | N_SW | Per-switch current-limit flag for the ending cycle |
| run_sel_i | input | 1 | Run length select: 0 = 8 cycles, 1 = 16 cycles |
| mode_exit_i | input | 1 | Mode-exit clear for the count and the fault |
| conv_en_req_i | input | 1 | Converter enable request from the mode controller |
| ichg_req_i | input | IW | Requested charge current code |
| fault_o | output | 1 | Latched overcurrent fault |
| run_cnt_o | output | CNT_W | Current consecutive-hit run count |
| conv_en_o | output | 1 | Gated converter enable |
| ichg_o | output | IW | Gated charge current code |

## Verification
The assertions assume a few things about the inputs. The strobe is a synchronous level that is sampled only at rising edges. The clear is synchronous. `run_sel_i` may change between strobes. Under those assumptions, the count and the fault can only move on a strobe or a clear.

The stimulus drives every input on the falling edge and keeps each input fixed for a whole clock. It places off-strobe flag activity between strobes, and it puts one clear on the same clock as a hit strobe to test the priority rule. It changes the run length select in the middle of a run only between strobes.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic {
    RUN_SHORT_SEL = 1'b0,
    RUN_LONG_SEL  = 1'b1
  } run_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIT  = 2'd1,
    ST_MISS = 2'd2,
    ST_CLR  = 2'd3
  } cyc_ev_e;
endpackage

// File: rtl/oc_run_counter.sv
module oc_run_counter #(
  parameter int RUN_LONG = 16,
  localparam int CNT_W = $clog2(RUN_LONG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  oc_pkg::cyc_ev_e  ev_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic [CNT_W-1:0] cnt_o
);
  import oc_pkg::*;

  localparam logic [CNT_W-1:0] CntMax = CNT_W'(RUN_LONG);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_nxt_o = cnt_q;
    unique case (ev_i)
      ST_CLR:  cnt_nxt_o = '0;
      ST_MISS: cnt_nxt_o = '0;
      ST_HIT:  cnt_nxt_o = (cnt_q == CntMax) ? CntMax : cnt_q + 1'b1;
      default: cnt_nxt_o = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/oc_fault_latch.sv
module oc_fault_latch #(
  parameter int RUN_SHORT = 8,
  parameter int RUN_LONG  = 16,
  localparam int CNT_W = $clog2(RUN_LONG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  oc_pkg::cyc_ev_e  ev_i,
  input  oc_pkg::run_sel_e sel_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output logic             fault_o
);
  import oc_pkg::*;

  localparam logic [CNT_W-1:0] LimShort = CNT_W'(RUN_SHORT);
  localparam logic [CNT_W-1:0] LimLong  = CNT_W'(RUN_LONG);

  logic [CNT_W-1:0] lim;
  logic             trip;
  logic             fault_q;

  assign lim  = (sel_i == RUN_LONG_SEL) ? LimLong : LimShort;
  assign trip = (ev_i == ST_HIT) && (cnt_nxt_i >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              fault_q <= 1'b0;
    else if (ev_i == ST_CLR)  fault_q <= 1'b0;  // mode exit wins
    else if (trip)            fault_q <= 1'b1;
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/oc_out_gate.sv
module oc_out_gate #(
  parameter int IW = 8
) (
  input  logic          fault_i,
  input  logic          en_req_i,
  input  logic [IW-1:0] ichg_req_i,
  output logic          en_o,
  output logic [IW-1:0] ichg_o
);
  assign en_o   = en_req_i & ~fault_i;
  assign ichg_o = fault_i ? '0 : ichg_req_i;
endmodule

// File: rtl/oc_run_fault.sv
module oc_run_fault #(
  parameter int N_SW      = 4,
  parameter int RUN_SHORT = 8,
  parameter int RUN_LONG  = 16,
  parameter int IW        = 8,
  localparam int CNT_W = $clog2(RUN_LONG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_stb_i,
  input  logic [N_SW-1:0]  lim_hit_i,
  input  logic             run_sel_i,
  input  logic             mode_exit_i,
  input  logic             conv_en_req_i,
  input  logic [IW-1:0]    ichg_req_i,
  output logic             fault_o,
  output logic [CNT_W-1:0] run_cnt_o,
  output logic             conv_en_o,
  output logic [IW-1:0]    ichg_o
);
  import oc_pkg::*;

  logic             any_hit;
  cyc_ev_e          ev;
  run_sel_e         sel;
  logic [CNT_W-1:0] cnt_nxt;
  logic             fault;

  assign any_hit = |lim_hit_i;
  assign sel     = run_sel_e'(run_sel_i);

  always_comb begin
    if (mode_exit_i)    ev = ST_CLR;
    else if (!cyc_stb_i) ev = ST_IDLE;
    else if (any_hit)   ev = ST_HIT;
    else                ev = ST_MISS;
  end

  oc_run_counter #(.RUN_LONG(RUN_LONG)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .cnt_nxt_o (cnt_nxt),
    .cnt_o     (run_cnt_o)
  );

  oc_fault_latch #(.RUN_SHORT(RUN_SHORT), .RUN_LONG(RUN_LONG)) i_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .sel_i     (sel),
    .cnt_nxt_i (cnt_nxt),
    .fault_o   (fault)
  );

  oc_out_gate #(.IW(IW)) i_gate (
    .fault_i    (fault),
    .en_req_i   (conv_en_req_i),
    .ichg_req_i (ichg_req_i),
    .en_o       (conv_en_o),
    .ichg_o     (ichg_o)
  );

  assign fault_o = fault;
endmodule

// File: rtl/oc_run_fault_chk.sv
module oc_run_fault_chk #(
  parameter int N_SW      = 4,
  parameter int RUN_SHORT = 8,
  parameter int RUN_LONG  = 16,
  parameter int IW        = 8,
  localparam int CNT_W = $clog2(RUN_LONG + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cyc_stb_i,
  input logic [N_SW-1:0]  lim_hit_i,
  input logic             run_sel_i,
  input logic             mode_exit_i,
  input logic             conv_en_req_i,
  input logic [IW-1:0]    ichg_req_i,
  input logic             fault_o,
  input logic [CNT_W-1:0] run_cnt_o,
  input logic             conv_en_o,
  input logic [IW-1:0]    ichg_o
);
  localparam logic [CNT_W-1:0] Lmax = CNT_W'(RUN_LONG);
  localparam logic [CNT_W-1:0] Lmin = CNT_W'(RUN_SHORT);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt_o <= Lmax) else $error("cnt bound"); // R2

  AST_HIT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_stb_i && (|lim_hit_i) && !mode_exit_i && run_cnt_o < Lmax
    |=> run_cnt_o == CNT_W'($past(run_cnt_o) + 1'b1)) else $error("inc"); // R2

  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_stb_i && !(|lim_hit_i) && !mode_exit_i |=> run_cnt_o == '0) else $error("miss"); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_stb_i && !mode_exit_i |=> $stable(run_cnt_o) && $stable(fault_o)) else $error("idle"); // R4

  AST_FAULT_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o ##1 fault_o |-> run_cnt_o >= Lmin) else $error("qual"); // R5

  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !mode_exit_i |=> fault_o) else $error("hold"); // R8

  AST_EXIT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_exit_i |=> !fault_o && run_cnt_o == '0) else $error("clr"); // R9

  AST_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !conv_en_o && ichg_o == '0) else $error("gate"); // R11

  AST_GATE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> conv_en_o == conv_en_req_i && ichg_o == ichg_req_i) else $error("pass"); // R11
endmodule

bind oc_run_fault oc_run_fault_chk #(
  .N_SW(N_SW), .RUN_SHORT(RUN_SHORT), .RUN_LONG(RUN_LONG), .IW(IW)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cyc_stb_i(cyc_stb_i), .lim_hit_i(lim_hit_i),
  .run_sel_i(run_sel_i), .mode_exit_i(mode_exit_i), .conv_en_req_i(conv_en_req_i),
  .ichg_req_i(ichg_req_i), .fault_o(fault_o), .run_cnt_o(run_cnt_o),
  .conv_en_o(conv_en_o), .ichg_o(ichg_o)
);

// File: tb/test_oc_run_fault.sv
module test_oc_run_fault;
  localparam int N_SW = 4;
  localparam int IW   = 8;
  localparam int CW   = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            stb = 1'b0;
  logic [N_SW-1:0] hit = '0;
  logic            sel = 1'b0;
  logic            clr = 1'b0;
  logic            en_req = 1'b1;
  logic [IW-1:0]   ichg_req = 8'h5A;
  logic            fault;
  logic [CW-1:0]   cnt;
  logic            en;
  logic [IW-1:0]   ichg;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [CW-1:0] cnt;
    logic          fault;
    logic          en;
    logic [IW-1:0] ichg;
    string         req;
  } exp_t;

  exp_t q[$];
  int   m_cnt = 0;
  bit   m_flt = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  oc_run_fault #(.N_SW(N_SW), .IW(IW)) i_oc_run_fault (
    .clk_i(clk), .rst_ni(rst_n), .cyc_stb_i(stb), .lim_hit_i(hit),
    .run_sel_i(sel), .mode_exit_i(clr), .conv_en_req_i(en_req),
    .ichg_req_i(ichg_req), .fault_o(fault), .run_cnt_o(cnt),
    .conv_en_o(en), .ichg_o(ichg)
  );

  task automatic step(input logic s, input logic [N_SW-1:0] h, input logic rs,
                      input logic c, input logic e, input logic [IW-1:0] ic,
                      input string req);
    exp_t x;
    @(negedge clk);
    stb = s; hit = h; sel = rs; clr = c; en_req = e; ichg_req = ic;
    if (c) begin
      m_cnt = 0; m_flt = 1'b0;
    end else if (s) begin
      if (|h) begin
        if (m_cnt < 16) m_cnt++;
        if (m_cnt >= (rs ? 16 : 8)) m_flt = 1'b1;
      end else m_cnt = 0;
    end
    x.cnt = CW'(m_cnt); x.fault = m_flt;
    x.en = e & ~m_flt; x.ichg = m_flt ? '0 : ic; x.req = req;
    q.push_back(x);
  endtask

  initial begin : monitor
    exp_t x;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        x = q.pop_front();
        n_chk++;
        if (cnt !== x.cnt || fault !== x.fault || en !== x.en || ichg !== x.ichg) begin
          n_bad++;
          $display("FAIL %s: cnt=%0d fault=%b en=%b ichg=%h exp cnt=%0d fault=%b en=%b ichg=%h",
                   x.req, cnt, fault, en, ichg, x.cnt, x.fault, x.en, x.ichg);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    #35;
    n_chk++;
    if (cnt !== '0 || fault !== 1'b0 || en !== 1'b1 || ichg !== 8'h5A) begin
      n_bad++;
      $display("FAIL R1: cnt=%0d fault=%b en=%b ichg=%h exp 0 0 1 5a", cnt, fault, en, ichg);
    end
    @(negedge clk); rst_n = 1'b1;

    // R5 / R7: short window, switches rotate, fault only on 8th
    for (int i = 0; i < 7; i++) step(1, 4'(1 << (i % N_SW)), 0, 0, 1, 8'h33, "R7");
    step(0, 4'hF, 0, 0, 1, 8'h33, "R4");
    step(1, 4'h2, 0, 0, 1, 8'h33, "R5");
    // R8: held through miss and idle
    step(1, 4'h0, 0, 0, 1, 8'h77, "R8");
    step(0, 4'h0, 1, 0, 1, 8'h77, "R8");
    step(1, 4'h0, 0, 0, 0, 8'h11, "R11");
    // R9: clear beats a hit strobe
    step(1, 4'h1, 0, 1, 1, 8'h44, "R9");
    step(1, 4'h1, 0, 0, 1, 8'h44, "R9");
    // R3: miss resets run
    for (int i = 0; i < 4; i++) step(1, 4'h8, 0, 0, 1, 8'h20, "R2");
    step(1, 4'h0, 0, 0, 1, 8'h20, "R3");
    // R4: off-strobe flags ignored
    for (int i = 0; i < 3; i++) step(0, 4'hF, 0, 0, 1, 8'h21, "R4");
    // R6: long window
    for (int i = 0; i < 15; i++) step(1, 4'(1 << (i % N_SW)), 1, 0, 1, 8'h22, "R6");
    step(1, 4'h4, 1, 0, 1, 8'h22, "R6");
    for (int i = 0; i < 3; i++) step(1, 4'h1, 1, 0, 1, 8'h22, "R2");
    step(0, 4'h0, 1, 1, 1, 8'h23, "R9");
    // R10: select switched mid-run, between strobes
    for (int i = 0; i < 10; i++) step(1, 4'h1, 1, 0, 1, 8'h24, "R10");
    step(0, 4'h0, 0, 0, 1, 8'h24, "R10");
    step(1, 4'h3, 0, 0, 1, 8'h24, "R10");
    step(0, 4'h0, 0, 1, 1, 8'h25, "R9");
    step(0, 4'h0, 0, 0, 0, 8'hC3, "R11");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule